// File: doc/BRIEF.md
# Lockable Paged One-Time-Programmable Byte Store

This block holds a small one-time-programmable memory behind a parallel, byte-wide command port. The port stands in for a single-wire serial host, so each command arrives as one opcode, one address and one data byte. The data area is 128 bytes, split into four pages of 32 bytes. Address bits [6:5] select the page and bits [4:0] select the byte within it. A separate area of eight status bytes is kept apart from the data. Status byte 0 carries one write-enable bit per page, and a page is locked once its bit has been programmed to zero. Storage only ever loses ones: programming stores the old value AND the new value, and a blank byte reads 0xFF. Asserting reset returns the model to the blank state.

A program command does not commit at once. It parks the byte and raises `busy`. The byte is written on the next `prog_pulse` strobe, and the block then answers with the byte read back from the array. Reads start at an address and then stream forward with a next-byte command until the end of the array. After the last byte, each further next-byte request gives 0xFF with the end flag and no data-valid. Every data-carrying answer has a CRC-8 beside it that the host can check. The device also returns a fixed 64-bit identifier one byte at a time.

Top module: `otp_page_ctrl`

## Requirements
- R1: After reset, every data and status byte reads 0xFF, `busy` is low and `rsp_valid`, `rsp_err` and `rsp_end` are low.
- R2: Opcode 0 (start read) returns the data byte at `cmd_addr` on `rsp_data`, with `rsp_valid` high, one clock after the command is taken. `rsp_crc` is the CRC-8 over the opcode byte, the address byte and the data byte, fed in that order. The CRC uses polynomial x^8+x^5+x^4+1 (reflected form 0x8C), starts from zero and takes each byte least-significant bit first.
- R3: Opcode 1 (next byte) returns the byte after the last one read. `rsp_crc` carries the running CRC, extended by the new data byte.
- R4: Once byte 127 has been read, or if no read has been started since reset, opcode 1 answers with `rsp_valid` low, `rsp_end` high and `rsp_data` 0xFF. This repeats for every further request.
- R5: Opcode 2 (program data) to an unlocked page raises `busy` and gives no response. The array stays unchanged until `prog_pulse` is seen.
- R6: On `prog_pulse` while `busy`, the addressed byte becomes old AND new and `busy` falls. The next cycle shows `rsp_valid` high, the stored byte on `rsp_data`, and the CRC-8 over the opcode, the address and the stored byte.
- R7: When bit p of status byte 0 is 0, opcode 2 to page p (address bits [6:5] = p) gives `rsp_err` high for one cycle. `busy` stays low and the byte is not changed.
- R8: Opcode 3 (program status) addresses status byte `cmd_addr[2:0]`. It waits for `prog_pulse` in the same way and also stores old AND new.
- R9: Opcode 4 returns status byte `cmd_addr[2:0]`. Opcode 5 returns byte `cmd_addr[2:0]` of the 64-bit identifier (byte 0 = bits [7:0]). Both answer like R2, with the CRC over opcode, address and data.
- R10: While `busy`, commands are ignored. While not `busy`, `prog_pulse` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode (0 read start, 1 next, 2 program data, 3 program status, 4 read status, 5 read identifier) |
| cmd_addr | input | 7 | Byte address, or status or identifier index in bits [2:0] |
| cmd_data | input | 8 | Byte to program |
| prog_pulse | input | 1 | Programming strobe that commits a parked byte |
| busy | output | 1 | A program byte is waiting for its strobe |
| rsp_valid | output | 1 | Response byte valid |
| rsp_data | output | 8 | Response byte |
| rsp_crc | output | 8 | CRC-8 of the response transaction |
| rsp_err | output | 1 | Program request rejected because its page is locked |
| rsp_end | output | 1 | Read pointer past the end of the array |

## Verification
The hardest state to reach from the ports is a parked program byte that meets unrelated traffic: commands arriving while `busy`, or idle gaps of varying length before the strobe. Both the random and the directed sequences hold the strobe back for some cycles and issue a read during the wait, then confirm that nothing answered and that the byte commits only on the strobe. A locked page is reached by programming status byte 0 first. The end of the array is reached by starting a read just below address 127 and stepping past it twice.

// File: rtl/otp_pkg.sv
package otp_pkg;
  typedef enum logic [2:0] {
    OP_RD_START = 3'd0,
    OP_RD_NEXT  = 3'd1,
    OP_PRG_DATA = 3'd2,
    OP_PRG_STAT = 3'd3,
    OP_RD_STAT  = 3'd4,
    OP_RD_ID    = 3'd5
  } otp_op_e;

  localparam logic [7:0] CRC_POLY_REFL = 8'h8C;
  localparam logic [7:0] BLANK_BYTE    = 8'hFF;
endpackage

// File: rtl/otp_crc8.sv
module otp_crc8
  import otp_pkg::*;
#(
  parameter int NBYTES = 3
) (
  input  logic [7:0]          seed,
  input  logic [8*NBYTES-1:0] bytes_in,
  output logic [7:0]          crc_out
);
  logic [7:0] stage [NBYTES+1];

  assign stage[0] = seed;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic [7:0] bitc [9];
    assign bitc[0] = stage[b];
    for (genvar i = 0; i < 8; i++) begin : g_bit
      logic fb;
      assign fb = bitc[i][0] ^ bytes_in[8*b+i];
      assign bitc[i+1] = (bitc[i] >> 1) ^ (fb ? CRC_POLY_REFL : 8'h00);
    end
    assign stage[b+1] = bitc[8];
  end

  assign crc_out = stage[NBYTES];
endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_pkg::*;
#(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 32,
  parameter int STAT_BYTES = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int PG_W      = $clog2(PAGES),
  localparam int ADDR_W    = OFF_W + PG_W,
  localparam int SA_W      = $clog2(STAT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_stat,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_mask,
  output logic [7:0]        wr_cur,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [SA_W-1:0]   st_addr,
  output logic [7:0]        st_data,
  output logic [PAGES-1:0]  page_open
);
  logic [PAGES-1:0][7:0] page_rd;
  logic [PAGES-1:0][7:0] page_cur;
  logic [7:0]            stat_q [STAT_BYTES];

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    logic [7:0] cell_q [PAGE_BYTES];
    logic       sel;

    assign sel = wr_en && !wr_stat && (wr_addr[ADDR_W-1:OFF_W] == PG_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int k = 0; k < PAGE_BYTES; k++) cell_q[k] <= BLANK_BYTE;
      end else if (sel) begin
        cell_q[wr_addr[OFF_W-1:0]] <= cell_q[wr_addr[OFF_W-1:0]] & wr_mask;
      end
    end

    assign page_rd[p]  = cell_q[rd_addr[OFF_W-1:0]];
    assign page_cur[p] = cell_q[wr_addr[OFF_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAT_BYTES; k++) stat_q[k] <= BLANK_BYTE;
    end else if (wr_en && wr_stat) begin
      stat_q[wr_addr[SA_W-1:0]] <= stat_q[wr_addr[SA_W-1:0]] & wr_mask;
    end
  end

  assign rd_data   = page_rd[rd_addr[ADDR_W-1:OFF_W]];
  assign wr_cur    = wr_stat ? stat_q[wr_addr[SA_W-1:0]] : page_cur[wr_addr[ADDR_W-1:OFF_W]];
  assign st_data   = stat_q[st_addr];
  assign page_open = stat_q[0][PAGES-1:0];
endmodule

// File: rtl/otp_page_ctrl.sv
module otp_page_ctrl
  import otp_pkg::*;
#(
  parameter int          PAGES      = 4,
  parameter int          PAGE_BYTES = 32,
  parameter int          STAT_BYTES = 8,
  parameter logic [63:0] DEV_ID     = 64'h5A3C_9E17_0B84_D2E1,
  localparam int         OFF_W      = $clog2(PAGE_BYTES),
  localparam int         PG_W       = $clog2(PAGES),
  localparam int         ADDR_W     = OFF_W + PG_W,
  localparam int         SA_W       = $clog2(STAT_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              prog_pulse,
  output logic              busy,
  output logic              rsp_valid,
  output logic [7:0]        rsp_data,
  output logic [7:0]        rsp_crc,
  output logic              rsp_err,
  output logic              rsp_end
);
  // pointer with one extra bit that marks "past the end"
  logic [ADDR_W:0]   ptr_q, ptr_d;
  logic [7:0]        crc_q, crc_d;
  logic              pend_q, pend_d;
  logic              pend_stat_q, pend_stat_d;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_d;
  logic [7:0]        pend_data_q, pend_data_d;
  logic              rv_q, rv_d;
  logic              rerr_q, rerr_d;
  logic              rend_q, rend_d;
  logic [7:0]        rdat_q, rdat_d;
  logic [7:0]        rcrc_q, rcrc_d;

  otp_op_e           op;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data, st_data, wr_cur, commit_val, id_byte;
  logic [PAGES-1:0]  page_open;
  logic              locked, commit;
  logic [7:0]        shot_cmd, shot_addr, shot_data, shot_crc, step_crc;

  assign op         = otp_op_e'(cmd_op);
  assign commit     = pend_q && prog_pulse;
  assign rd_addr    = (op == OP_RD_START) ? cmd_addr : ptr_q[ADDR_W-1:0];
  assign commit_val = wr_cur & pend_data_q;
  assign locked     = !page_open[cmd_addr[ADDR_W-1:OFF_W]];
  assign id_byte    = DEV_ID[{cmd_addr[2:0], 3'b000} +: 8];

  otp_store #(
    .PAGES     (PAGES),
    .PAGE_BYTES(PAGE_BYTES),
    .STAT_BYTES(STAT_BYTES)
  ) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (commit),
    .wr_stat  (pend_stat_q),
    .wr_addr  (pend_addr_q),
    .wr_mask  (pend_data_q),
    .wr_cur   (wr_cur),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .st_addr  (cmd_addr[SA_W-1:0]),
    .st_data  (st_data),
    .page_open(page_open)
  );

  // one-shot transaction CRC: opcode, address, data
  always_comb begin
    if (pend_q) begin
      shot_cmd  = pend_stat_q ? 8'(OP_PRG_STAT) : 8'(OP_PRG_DATA);
      shot_addr = 8'(pend_addr_q);
      shot_data = commit_val;
    end else begin
      shot_cmd  = 8'(cmd_op);
      shot_addr = 8'(cmd_addr);
      case (op)
        OP_RD_STAT: shot_data = st_data;
        OP_RD_ID:   shot_data = id_byte;
        default:    shot_data = rd_data;
      endcase
    end
  end

  otp_crc8 #(.NBYTES(3)) i_crc_shot (
    .seed    (8'h00),
    .bytes_in({shot_data, shot_addr, shot_cmd}),
    .crc_out (shot_crc)
  );

  otp_crc8 #(.NBYTES(1)) i_crc_step (
    .seed    (crc_q),
    .bytes_in(rd_data),
    .crc_out (step_crc)
  );

  // next-state logic
  always_comb begin
    ptr_d       = ptr_q;
    crc_d       = crc_q;
    pend_d      = pend_q;
    pend_stat_d = pend_stat_q;
    pend_addr_d = pend_addr_q;
    pend_data_d = pend_data_q;
    rv_d        = 1'b0;
    rerr_d      = 1'b0;
    rend_d      = 1'b0;
    rdat_d      = rdat_q;
    rcrc_d      = rcrc_q;
    if (pend_q) begin
      if (prog_pulse) begin
        pend_d = 1'b0;
        rv_d   = 1'b1;
        rdat_d = commit_val;
        rcrc_d = shot_crc;
      end
    end else if (cmd_valid) begin
      case (op)
        OP_RD_START: begin
          rv_d   = 1'b1;
          rdat_d = rd_data;
          rcrc_d = shot_crc;
          crc_d  = shot_crc;
          ptr_d  = {1'b0, cmd_addr} + 1'b1;
        end
        OP_RD_NEXT: begin
          if (ptr_q[ADDR_W]) begin
            rend_d = 1'b1;
            rdat_d = BLANK_BYTE;
          end else begin
            rv_d   = 1'b1;
            rdat_d = rd_data;
            rcrc_d = step_crc;
            crc_d  = step_crc;
            ptr_d  = ptr_q + 1'b1;
          end
        end
        OP_PRG_DATA: begin
          if (locked) begin
            rerr_d = 1'b1;
          end else begin
            pend_d      = 1'b1;
            pend_stat_d = 1'b0;
            pend_addr_d = cmd_addr;
            pend_data_d = cmd_data;
          end
        end
        OP_PRG_STAT: begin
          pend_d      = 1'b1;
          pend_stat_d = 1'b1;
          pend_addr_d = cmd_addr;
          pend_data_d = cmd_data;
        end
        OP_RD_STAT, OP_RD_ID: begin
          rv_d   = 1'b1;
          rdat_d = shot_data;
          rcrc_d = shot_crc;
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= {1'b1, {ADDR_W{1'b0}}};
      crc_q  <= 8'h00;
      pend_q <= 1'b0;
      rv_q   <= 1'b0;
      rerr_q <= 1'b0;
      rend_q <= 1'b0;
      rdat_q <= 8'h00;
      rcrc_q <= 8'h00;
    end else begin
      ptr_q  <= ptr_d;
      crc_q  <= crc_d;
      pend_q <= pend_d;
      rv_q   <= rv_d;
      rerr_q <= rerr_d;
      rend_q <= rend_d;
      rdat_q <= rdat_d;
      rcrc_q <= rcrc_d;
    end
  end

  // pending payload, loaded only when a program command is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_stat_q <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= 8'h00;
    end else if (pend_d && !pend_q) begin
      pend_stat_q <= pend_stat_d;
      pend_addr_q <= pend_addr_d;
      pend_data_q <= pend_data_d;
    end
  end

  assign busy      = pend_q;
  assign rsp_valid = rv_q;
  assign rsp_data  = rdat_q;
  assign rsp_crc   = rcrc_q;
  assign rsp_err   = rerr_q;
  assign rsp_end   = rend_q;
endmodule

// File: rtl/otp_page_ctrl_chk.sv
module otp_page_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       prog_pulse,
  input logic       busy,
  input logic       rsp_valid,
  input logic       rsp_err,
  input logic       rsp_end,
  input logic [7:0] rsp_data,
  input logic [7:0] pend_data
);
  p_wait_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !prog_pulse |=> busy && !rsp_valid && !rsp_err && !rsp_end);

  p_commit_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && prog_pulse |=> rsp_valid && !busy);

  p_commit_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && prog_pulse |=> (rsp_data & ~$past(pend_data)) == 8'h00);

  p_one_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, rsp_err, rsp_end}));

  p_end_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_end |-> rsp_data == 8'hFF);

  p_reject_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !busy);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !cmd_valid |=> !busy && !rsp_valid && !rsp_err && !rsp_end);
endmodule

bind otp_page_ctrl otp_page_ctrl_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .prog_pulse(prog_pulse),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_end   (rsp_end),
  .rsp_data  (rsp_data),
  .pend_data (pend_data_q)
);

// File: tb/test_otp_page_ctrl.sv
module test_otp_page_ctrl;
  localparam int          CLK_PERIOD = 10;
  localparam logic [63:0] ID         = 64'h5A3C_9E17_0B84_D2E1;

  logic       clk, rst_n, cmd_valid, prog_pulse;
  logic [2:0] cmd_op;
  logic [6:0] cmd_addr;
  logic [7:0] cmd_data;
  logic       busy, rsp_valid, rsp_err, rsp_end;
  logic [7:0] rsp_data, rsp_crc;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0] mem_m  [128];
  logic [7:0] stat_m [8];
  int         ptr_m;
  logic [7:0] crc_m;

  otp_page_ctrl #(.DEV_ID(ID)) i_otp_page_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .prog_pulse(prog_pulse),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_crc(rsp_crc),
    .rsp_err(rsp_err), .rsp_end(rsp_end)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic f = r[0] ^ b[i];
      r = r >> 1;
      if (f) r = r ^ 8'h8C;
    end
    return r;
  endfunction

  function automatic logic [7:0] crc3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] d);
    return crc_byte(crc_byte(crc_byte(8'h00, a), b), d);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // flags packed as {valid, err, end, busy}
  task automatic expect_rsp(input string req, input logic [3:0] flags,
                            input logic [7:0] d, input logic [7:0] c, input bit use_data);
    check(req, {rsp_valid, rsp_err, rsp_end, busy}, flags);
    if (use_data) check(req, {rsp_data, rsp_crc}, {d, c});
  endtask

  task automatic issue(input logic [2:0] op, input logic [6:0] a, input logic [7:0] d);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic pulse();
    prog_pulse = 1'b1;
    @(negedge clk);
    prog_pulse = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [6:0] a);
    issue(3'd0, a, 8'h00);
    crc_m = crc3(8'd0, {1'b0, a}, mem_m[a]);
    ptr_m = a + 1;
    expect_rsp(req, 4'b1000, mem_m[a], crc_m, 1);
  endtask

  task automatic do_next(input string req);
    issue(3'd1, 7'd0, 8'h00);
    if (ptr_m > 127) begin
      expect_rsp(req, 4'b0010, 8'hFF, 8'h00, 0);
      check(req, rsp_data, 8'hFF);
    end else begin
      crc_m = crc_byte(crc_m, mem_m[ptr_m]);
      expect_rsp(req, 4'b1000, mem_m[ptr_m], crc_m, 1);
      ptr_m++;
    end
  endtask

  task automatic do_prog(input string req, input bit stat, input logic [6:0] a,
                         input logic [7:0] d, input int gap, input bit cut_in);
    logic [7:0] nv;
    issue(stat ? 3'd3 : 3'd2, a, d);
    if (!stat && !stat_m[0][a[6:5]]) begin
      expect_rsp(req, 4'b0100, 8'h00, 8'h00, 0);
      return;
    end
    expect_rsp(req, 4'b0001, 8'h00, 8'h00, 0);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      expect_rsp(req, 4'b0001, 8'h00, 8'h00, 0);
    end
    if (cut_in) begin
      issue(3'd0, a, 8'h00);
      expect_rsp("R10 command while busy", 4'b0001, 8'h00, 8'h00, 0);
    end
    pulse();
    if (stat) begin
      nv = stat_m[a[2:0]] & d;
      stat_m[a[2:0]] = nv;
    end else begin
      nv = mem_m[a] & d;
      mem_m[a] = nv;
    end
    expect_rsp(req, 4'b1000, nv, crc3(stat ? 8'd3 : 8'd2, {1'b0, a}, nv), 1);
  endtask

  task automatic do_stat(input string req, input logic [2:0] i);
    issue(3'd4, {4'd0, i}, 8'h00);
    expect_rsp(req, 4'b1000, stat_m[i], crc3(8'd4, {5'd0, i}, stat_m[i]), 1);
  endtask

  task automatic do_id(input string req, input logic [2:0] i);
    logic [7:0] b = ID[{i, 3'b000} +: 8];
    issue(3'd5, {4'd0, i}, 8'h00);
    expect_rsp(req, 4'b1000, b, crc3(8'd5, {5'd0, i}, b), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 128; k++) mem_m[k] = 8'hFF;
    for (int k = 0; k < 8; k++) stat_m[k] = 8'hFF;
    ptr_m = 128; crc_m = 8'h00;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_addr = 7'd0;
    cmd_data = 8'h00; prog_pulse = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_rsp("R1 reset flags", 4'b0000, 8'h00, 8'h00, 0);
    do_stat("R1 blank status", 3'd0);
    do_read("R1 R2 blank data", 7'd0);
    do_next("R3 next after start");

    // R5 R6 program with wait and an intruding command
    do_prog("R5 R6 first program", 0, 7'd40, 8'hA5, 2, 1);
    do_prog("R6 and-accumulate", 0, 7'd40, 8'h0F, 0, 0);
    do_read("R6 readback", 7'd40);

    // R10 strobe while idle changes nothing
    pulse();
    expect_rsp("R10 idle pulse", 4'b0000, 8'h00, 8'h00, 0);
    do_read("R10 data kept", 7'd40);

    // R3 R4 stream over the end
    do_read("R2 near end", 7'd125);
    do_next("R3 byte 126");
    do_next("R3 byte 127");
    do_next("R4 past end");
    do_next("R4 past end again");

    // R7 R8 lock page 2
    do_prog("R8 lock page 2", 1, 7'd0, 8'hFB, 1, 0);
    do_stat("R9 status readback", 3'd0);
    do_prog("R7 locked page write", 0, 7'd70, 8'h00, 0, 0);
    do_read("R7 locked byte unchanged", 7'd70);
    do_prog("R7 other page still open", 0, 7'd33, 8'h3C, 0, 0);
    do_id("R9 id byte 3", 3'd3);
    do_id("R9 id byte 7", 3'd7);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int r = $urandom % 16;
      logic [6:0] a = 7'($urandom);
      logic [7:0] d = 8'($urandom);
      if (r < 5)       do_prog("R6 R7 random program", 0, a, d, $urandom % 3, ($urandom % 4) == 0);
      else if (r == 5) do_prog("R8 random status", 1, {4'd0, a[2:0]}, (a[2:0] == 3'd0) ? (d | 8'h07) : d, $urandom % 2, 0);
      else if (r < 10) do_read("R2 random read", a);
      else if (r < 14) do_next("R3 R4 random next");
      else if (r == 14) do_stat("R9 random status read", a[2:0]);
      else             do_id("R9 random id read", a[2:0]);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule